// File: doc/BRIEF.md
# NAND Flash Identification Sequencer

This block works out which raw NAND flash part sits on an 8-bit asynchronous bus after power-up, with no software involved. Once pulsed with `start`, it waits for the part to signal ready. It then resets the part and tries the ONFI identity probe. If the probe answers correctly, it streams the parameter page and picks out the geometry fields it needs.

If either ONFI signature check fails, the block takes a fallback path. It resets the part a second time, issues a plain Read ID, and matches the returned device code against a built-in table of sixteen legacy codes. Each table entry gives a bus width, and the geometry for these parts is fixed.

The sequencer drives a simple byte-cycle port. Each transfer is a command, address or read cycle, requested with `bus_req` and completed by `bus_ack`. The sequence ends either in a held result with `done` high, or in a sticky `fail` state.

Top module: `nand_id_seq`

## Requirements
- R1: After `start`, no bus cycle is issued until `rdy` is seen high. With L = CLK_KHZ*PWR_MS cycles:
  - if `rdy` is sampled high on the L-th cycle of waiting, the sequence continues;
  - if `rdy` is still low on that cycle, the sequence enters fail.
- R2: The first bus cycle is a command cycle carrying FFh. Readiness is then polled under a limit of CLK_KHZ*RST_MS cycles:
  - busy for exactly that many cycles still succeeds;
  - busy for one cycle more ends in fail after that single command.
- R3: The ONFI probe is a command cycle 90h, then an address cycle 20h, then four read cycles. The bytes read must be 4Fh, 4Eh, 46h, 49h in that order.
- R4: When the probe signature matches, a command cycle ECh follows, then read cycles. The first four page bytes must repeat the signature; otherwise the page read stops after byte 3. On a good page, exactly 102 bytes (offsets 0 to 101) are read before `done`, and `src_onfi` is 1.
- R5: The ONFI results are taken little-endian from these page offsets, with every other byte ignored:
  - `page_bytes` from offsets 80..83;
  - `pages_per_blk` from 92..95;
  - `spare_bytes` from 84..85;
  - `feat` from 6..7;
  - `addr_cycles` from 101.
- R6: After any ONFI signature mismatch, the block sends a second FFh command and waits for ready under the RST_MS limit. It then sends command 90h, address 00h and two read cycles, and the second byte read is the device code.
- R7: A device code found in the table gives `done` with `src_onfi` 0 and these fixed results:
  - `page_bytes` = TAB_PAGE (2048);
  - `spare_bytes` = TAB_PAGE/32;
  - `pages_per_blk` = TAB_BLK_PAGES (64);
  - `addr_cycles` = 0;
  - `feat[0]` = 1 for the x16 codes C0, B0, C2, B2, C1, B1, CA, BA, and 0 for the x8 codes F0, A0, F2, A2, F1, A1, DA, AA.
- R8: A device code not in the table ends in fail.
- R9: `done` and `fail` each hold, together with the results, until the next `start`. A `start` clears them and returns to the ready wait. All result outputs read zero whenever `done` is low.
- R10: `bus_op` encodes 0 = command, 1 = address, 2 = read. While `bus_req` is high without `bus_ack`, `bus_op` and `bus_wdata` stay stable. No request is made while `done` or `fail` is high or after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (50 MHz by default) |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin identification (accepted when idle, done or failed) |
| rdy | input | 1 | Ready/busy line from the flash, high when ready |
| bus_req | output | 1 | Byte cycle requested |
| bus_op | output | 2 | Cycle kind: 0 command, 1 address, 2 read |
| bus_wdata | output | 8 | Command or address byte |
| bus_ack | input | 1 | Cycle completes on a clock where `bus_req` and this are high |
| bus_rdata | input | 8 | Read byte, valid with `bus_ack` on a read cycle |
| done | output | 1 | Identification succeeded, results valid |
| fail | output | 1 | Identification failed (sticky) |
| src_onfi | output | 1 | 1 = results from parameter page, 0 = from table |
| feat | output | 16 | Feature word (table path: bit 0 = x16) |
| page_bytes | output | 32 | Data bytes per page |
| spare_bytes | output | 16 | Spare bytes per page |
| pages_per_blk | output | 32 | Pages per block |
| addr_cycles | output | 8 | Address cycle count (0 from table) |

## Verification
The bench builds the block with CLK_KHZ=1, PWR_MS=40 and RST_MS=30, so the power-up limit is 40 cycles and the reset limit is 30 cycles. At the defaults these limits are millions of cycles. The short values let the bench hit both timeout edges exactly, including one cycle inside and one cycle past each limit, within a short run. The geometry parameters keep their defaults, so the fixed table results are the 2048/64/64 values.

// File: rtl/nand_id_pkg.sv
package nand_id_pkg;

    typedef enum logic [1:0] {
        OP_CMD  = 2'd0,
        OP_ADDR = 2'd1,
        OP_READ = 2'd2
    } bus_op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_PWR_WAIT, S_RST_CMD, S_RST_WAIT,
        S_PID_CMD, S_PID_ADDR, S_PID_RD,
        S_PG_CMD, S_PG_RD,
        S_LID_CMD, S_LID_ADDR, S_LID_RD,
        S_LOOKUP, S_DONE, S_FAIL
    } seq_state_e;

    localparam logic [7:0] CMD_RESET   = 8'hFF;
    localparam logic [7:0] CMD_READ_ID = 8'h90;
    localparam logic [7:0] CMD_PARAM   = 8'hEC;
    localparam logic [7:0] ADR_ONFI    = 8'h20;
    localparam logic [7:0] ADR_LEGACY  = 8'h00;

    typedef struct packed {
        logic [15:0] feat;
        logic [31:0] page_bytes;
        logic [15:0] spare_bytes;
        logic [31:0] pages_per_blk;
        logic [7:0]  addr_cycles;
    } geom_t;

    // Expected signature byte for position 0..3 of an ONFI answer.
    function automatic logic [7:0] sig_byte(input logic [1:0] pos);
        case (pos)
            2'd0:    return 8'h4F;
            2'd1:    return 8'h4E;
            2'd2:    return 8'h46;
            default: return 8'h49;
        endcase
    endfunction

    // Legacy table: bit 8 set marks a 16-bit part, bits 7:0 the device code.
    localparam int unsigned ID_TAB_N = 16;
    localparam logic [ID_TAB_N-1:0][8:0] ID_TAB = {
        9'h0F0, 9'h0A0, 9'h0F2, 9'h0A2, 9'h0F1, 9'h0A1, 9'h0DA, 9'h0AA,
        9'h1C0, 9'h1B0, 9'h1C2, 9'h1B2, 9'h1C1, 9'h1B1, 9'h1CA, 9'h1BA
    };

endpackage

// File: rtl/nand_id_ready_timer.sv
module nand_id_ready_timer #(
    parameter int unsigned LIM_A = 100,
    parameter int unsigned LIM_B = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic sel_b,
    output logic expired
);
    localparam int unsigned LIM_MAX = (LIM_A > LIM_B) ? LIM_A : LIM_B;
    localparam int unsigned CNT_W   = $clog2(LIM_MAX + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;
    logic [CNT_W-1:0] last_d;

    always_comb begin
        last_d  = sel_b ? CNT_W'(LIM_B - 1) : CNT_W'(LIM_A - 1);
        expired = (t_q.cnt >= last_d);
        t_d     = t_q;
        if (clr)
            t_d.cnt = '0;
        else if (!expired)
            t_d.cnt = t_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    AST_TMR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !expired || (LIM_A == 1) || (LIM_B == 1)); // R1
endmodule

// File: rtl/nand_id_param_capture.sv
module nand_id_param_capture
    import nand_id_pkg::*;
#(
    parameter int unsigned IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             byte_vld,
    input  logic [IDX_W-1:0] byte_idx,
    input  logic [7:0]       byte_val,
    output geom_t            geom
);
    geom_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (clr) begin
            g_d = '0;
        end else if (byte_vld) begin
            case (int'(byte_idx))
                6:   g_d.feat[7:0]             = byte_val;
                7:   g_d.feat[15:8]            = byte_val;
                80:  g_d.page_bytes[7:0]       = byte_val;
                81:  g_d.page_bytes[15:8]      = byte_val;
                82:  g_d.page_bytes[23:16]     = byte_val;
                83:  g_d.page_bytes[31:24]     = byte_val;
                84:  g_d.spare_bytes[7:0]      = byte_val;
                85:  g_d.spare_bytes[15:8]     = byte_val;
                92:  g_d.pages_per_blk[7:0]    = byte_val;
                93:  g_d.pages_per_blk[15:8]   = byte_val;
                94:  g_d.pages_per_blk[23:16]  = byte_val;
                95:  g_d.pages_per_blk[31:24]  = byte_val;
                101: g_d.addr_cycles           = byte_val;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign geom = g_q;

    AST_CAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !byte_vld) |=> $stable(g_q)); // R5
endmodule

// File: rtl/nand_id_table.sv
module nand_id_table
    import nand_id_pkg::*;
#(
    parameter int unsigned PAGE_BYTES = 2048,
    parameter int unsigned BLK_PAGES  = 64
) (
    input  logic [7:0] dev_id,
    output logic       hit,
    output geom_t      geom
);
    localparam int unsigned SPARE_BYTES = PAGE_BYTES / 32;

    logic [ID_TAB_N-1:0] match;
    logic [ID_TAB_N-1:0] wide;

    for (genvar i = 0; i < ID_TAB_N; i++) begin : g_ent
        assign match[i] = (ID_TAB[i][7:0] == dev_id);
        assign wide[i]  = match[i] & ID_TAB[i][8];
    end

    always_comb begin
        hit                = |match;
        geom               = '0;
        geom.feat[0]       = |wide;
        geom.page_bytes    = 32'(PAGE_BYTES);
        geom.spare_bytes   = 16'(SPARE_BYTES);
        geom.pages_per_blk = 32'(BLK_PAGES);
    end
endmodule

// File: rtl/nand_id_seq.sv
module nand_id_seq
    import nand_id_pkg::*;
#(
    parameter int unsigned CLK_KHZ       = 50000,
    parameter int unsigned PWR_MS        = 250,
    parameter int unsigned RST_MS        = 200,
    parameter int unsigned TAB_PAGE      = 2048,
    parameter int unsigned TAB_BLK_PAGES = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        rdy,
    output logic        bus_req,
    output logic [1:0]  bus_op,
    output logic [7:0]  bus_wdata,
    input  logic        bus_ack,
    input  logic [7:0]  bus_rdata,
    output logic        done,
    output logic        fail,
    output logic        src_onfi,
    output logic [15:0] feat,
    output logic [31:0] page_bytes,
    output logic [15:0] spare_bytes,
    output logic [31:0] pages_per_blk,
    output logic [7:0]  addr_cycles
);
    localparam int unsigned PWR_CYC = CLK_KHZ * PWR_MS;
    localparam int unsigned RST_CYC = CLK_KHZ * RST_MS;
    localparam int unsigned PG_LAST = 101;
    localparam int unsigned IDX_W   = $clog2(PG_LAST + 1);

    typedef struct packed {
        seq_state_e       st;
        logic [IDX_W-1:0] idx;
        logic             sig_ok;
        logic             fb;
        logic             onfi;
        logic [7:0]       dev_id;
    } seq_t;

    localparam seq_t SEQ_RST = '{st: S_IDLE, idx: '0, sig_ok: 1'b0,
                                 fb: 1'b0, onfi: 1'b0, dev_id: 8'h00};

    seq_t  s_d, s_q;
    logic  tmr_clr, tmr_sel, tmr_exp;
    logic  cap_clr, cap_vld;
    logic  sig_m, tab_hit;
    geom_t cap_geom, tab_geom, out_geom;

    nand_id_ready_timer #(.LIM_A(PWR_CYC), .LIM_B(RST_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .sel_b(tmr_sel), .expired(tmr_exp)
    );

    nand_id_param_capture #(.IDX_W(IDX_W)) u_capture (
        .clk(clk), .rst_n(rst_n), .clr(cap_clr), .byte_vld(cap_vld),
        .byte_idx(s_q.idx), .byte_val(bus_rdata), .geom(cap_geom)
    );

    nand_id_table #(.PAGE_BYTES(TAB_PAGE), .BLK_PAGES(TAB_BLK_PAGES)) u_table (
        .dev_id(s_q.dev_id), .hit(tab_hit), .geom(tab_geom)
    );

    always_comb begin
        s_d       = s_q;
        bus_req   = 1'b0;
        bus_op    = OP_CMD;
        bus_wdata = 8'h00;
        tmr_clr   = 1'b1;
        tmr_sel   = 1'b0;
        cap_clr   = 1'b0;
        cap_vld   = 1'b0;
        sig_m     = (bus_rdata == sig_byte(s_q.idx[1:0]));

        case (s_q.st)
            S_IDLE, S_DONE, S_FAIL: begin
                if (start) begin
                    s_d     = SEQ_RST;
                    s_d.st  = S_PWR_WAIT;
                    cap_clr = 1'b1;
                end
            end
            S_PWR_WAIT: begin
                tmr_clr = 1'b0;
                if (rdy)          s_d.st = S_RST_CMD;
                else if (tmr_exp) s_d.st = S_FAIL;
            end
            S_RST_CMD: begin
                bus_req   = 1'b1;
                bus_wdata = CMD_RESET;
                if (bus_ack) s_d.st = S_RST_WAIT;
            end
            S_RST_WAIT: begin
                tmr_clr = 1'b0;
                tmr_sel = 1'b1;
                if (rdy)          s_d.st = s_q.fb ? S_LID_CMD : S_PID_CMD;
                else if (tmr_exp) s_d.st = S_FAIL;
            end
            S_PID_CMD: begin
                bus_req   = 1'b1;
                bus_wdata = CMD_READ_ID;
                if (bus_ack) s_d.st = S_PID_ADDR;
            end
            S_PID_ADDR: begin
                bus_req   = 1'b1;
                bus_op    = OP_ADDR;
                bus_wdata = ADR_ONFI;
                if (bus_ack) begin
                    s_d.st     = S_PID_RD;
                    s_d.idx    = '0;
                    s_d.sig_ok = 1'b1;
                end
            end
            S_PID_RD: begin
                bus_req = 1'b1;
                bus_op  = OP_READ;
                if (bus_ack) begin
                    s_d.sig_ok = s_q.sig_ok & sig_m;
                    s_d.idx    = s_q.idx + 1'b1;
                    if (s_q.idx == IDX_W'(3)) begin
                        s_d.st = (s_q.sig_ok && sig_m) ? S_PG_CMD : S_RST_CMD;
                        s_d.fb = !(s_q.sig_ok && sig_m);
                    end
                end
            end
            S_PG_CMD: begin
                bus_req   = 1'b1;
                bus_wdata = CMD_PARAM;
                if (bus_ack) begin
                    s_d.st     = S_PG_RD;
                    s_d.idx    = '0;
                    s_d.sig_ok = 1'b1;
                end
            end
            S_PG_RD: begin
                bus_req = 1'b1;
                bus_op  = OP_READ;
                if (bus_ack) begin
                    cap_vld = 1'b1;
                    s_d.idx = s_q.idx + 1'b1;
                    if (s_q.idx < IDX_W'(4))
                        s_d.sig_ok = s_q.sig_ok & sig_m;
                    if (s_q.idx == IDX_W'(3) && !(s_q.sig_ok && sig_m)) begin
                        s_d.st = S_RST_CMD;
                        s_d.fb = 1'b1;
                    end else if (s_q.idx == IDX_W'(PG_LAST)) begin
                        s_d.st   = S_DONE;
                        s_d.onfi = 1'b1;
                    end
                end
            end
            S_LID_CMD: begin
                bus_req   = 1'b1;
                bus_wdata = CMD_READ_ID;
                if (bus_ack) s_d.st = S_LID_ADDR;
            end
            S_LID_ADDR: begin
                bus_req   = 1'b1;
                bus_op    = OP_ADDR;
                bus_wdata = ADR_LEGACY;
                if (bus_ack) begin
                    s_d.st  = S_LID_RD;
                    s_d.idx = '0;
                end
            end
            S_LID_RD: begin
                bus_req = 1'b1;
                bus_op  = OP_READ;
                if (bus_ack) begin
                    s_d.idx = s_q.idx + 1'b1;
                    if (s_q.idx[0]) begin
                        s_d.dev_id = bus_rdata;
                        s_d.st     = S_LOOKUP;
                    end
                end
            end
            S_LOOKUP: s_d.st = tab_hit ? S_DONE : S_FAIL;
            default:  s_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= SEQ_RST;
        else        s_q <= s_d;
    end

    always_comb begin
        done     = (s_q.st == S_DONE);
        fail     = (s_q.st == S_FAIL);
        src_onfi = done & s_q.onfi;
        out_geom = '0;
        if (done) out_geom = s_q.onfi ? cap_geom : tab_geom;
    end

    assign feat          = out_geom.feat;
    assign page_bytes    = out_geom.page_bytes;
    assign spare_bytes   = out_geom.spare_bytes;
    assign pages_per_blk = out_geom.pages_per_blk;
    assign addr_cycles   = out_geom.addr_cycles;

    AST_WAIT_NO_EARLY_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st inside {S_PWR_WAIT, S_RST_WAIT}) && !tmr_exp |=> !fail); // R1
    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fail && !start |=> fail); // R9
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done && $stable(page_bytes) && $stable(pages_per_blk)); // R9
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_op) && $stable(bus_wdata)); // R10
    AST_QUIET_END: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fail) |-> !bus_req); // R10
    AST_TABLE_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        done && !src_onfi |-> page_bytes == 32'(TAB_PAGE)); // R7
endmodule

// File: tb/nand_id_seq_tb.sv
module nand_id_seq_tb;
    localparam int PWR_L = 40;
    localparam int RST_L = 30;

    logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic        rdy, bus_req, bus_ack = 1'b0;
    logic [1:0]  bus_op;
    logic [7:0]  bus_wdata, bus_rdata = 8'h00;
    logic        done, fail, src_onfi;
    logic [15:0] feat, spare_bytes;
    logic [31:0] page_bytes, pages_per_blk;
    logic [7:0]  addr_cycles;

    always #10 clk = ~clk;

    nand_id_seq #(.CLK_KHZ(1), .PWR_MS(PWR_L), .RST_MS(RST_L)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rdy(rdy),
        .bus_req(bus_req), .bus_op(bus_op), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .done(done), .fail(fail), .src_onfi(src_onfi), .feat(feat),
        .page_bytes(page_bytes), .spare_bytes(spare_bytes),
        .pages_per_blk(pages_per_blk), .addr_cycles(addr_cycles)
    );

    // ---------------- flash model ----------------
    logic        pwr_hold = 1'b0, id_ok = 1'b1, pg_ok = 1'b1;
    logic [7:0]  dev = 8'h00;
    int          rst_busy = 3;
    logic [15:0] m_feat = '0, m_spare = '0;
    logic [31:0] m_page = '0, m_ppb = '0;
    logic [7:0]  m_acyc = '0;
    int          busy = 0, rd_i = 0, n_cmd = 0, n_rd = 0;
    logic [7:0]  last_cmd = 8'h00, last_adr = 8'h00;
    logic [7:0]  cmd_log [64];

    assign rdy = !pwr_hold && (busy == 0);

    function automatic logic [7:0] sig_of(int i);
        case (i)
            0: return 8'h4F;
            1: return 8'h4E;
            2: return 8'h46;
            default: return 8'h49;
        endcase
    endfunction

    function automatic logic [7:0] page_of(int i);
        case (i)
            6: return m_feat[7:0];    7: return m_feat[15:8];
            80: return m_page[7:0];   81: return m_page[15:8];
            82: return m_page[23:16]; 83: return m_page[31:24];
            84: return m_spare[7:0];  85: return m_spare[15:8];
            92: return m_ppb[7:0];    93: return m_ppb[15:8];
            94: return m_ppb[23:16];  95: return m_ppb[31:24];
            101: return m_acyc;
            default: return 8'(i) ^ 8'hA5;
        endcase
    endfunction

    function automatic logic [7:0] read_of(int i);
        if (last_cmd == 8'hEC) begin
            if (i < 4) return (!pg_ok && i == 1) ? 8'h6E : sig_of(i);
            return page_of(i);
        end
        if (last_cmd == 8'h90 && last_adr == 8'h20)
            return (!id_ok && i == 2) ? 8'h00 : sig_of(i);
        if (last_cmd == 8'h90)
            return (i == 0) ? 8'h98 : (i == 1) ? dev : 8'h00;
        return 8'h00;
    endfunction

    always @(negedge clk) begin
        if (busy > 0) busy = busy - 1;
        bus_ack = 1'b0;
        if (bus_req) begin
            bus_ack = 1'b1;
            case (bus_op)
                2'd0: begin
                    cmd_log[n_cmd % 64] = bus_wdata;
                    n_cmd    = n_cmd + 1;
                    last_cmd = bus_wdata;
                    rd_i     = 0;
                    if (bus_wdata == 8'hFF) busy = rst_busy;
                end
                2'd1: begin
                    last_adr = bus_wdata;
                    rd_i     = 0;
                end
                default: begin
                    bus_rdata = read_of(rd_i);
                    rd_i      = rd_i + 1;
                    n_rd      = n_rd + 1;
                end
            endcase
        end
    end

    // ---------------- checking ----------------
    int n_chk = 0, n_bad = 0;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_id();
        int cyc;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        cyc = 0;
        while (!(done || fail) && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    typedef struct packed {
        logic        id_ok;
        logic        pg_ok;
        logic [7:0]  dev;
        logic        ok;
        logic        onfi;
        logic [15:0] feat;
        logic [31:0] page;
        logic [15:0] spare;
        logic [31:0] ppb;
        logic [7:0]  acyc;
        logic [3:0]  ncmd;
        logic [7:0]  nrd;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 8'h00, 1'b1, 1'b1, 16'h0019, 32'd4096, 16'd224, 32'd128, 8'h05, 4'd3, 8'd106},
        '{1'b1, 1'b1, 8'h00, 1'b1, 1'b1, 16'hB2A1, 32'h04030201, 16'h0A09, 32'h14131211, 8'h21, 4'd3, 8'd106},
        '{1'b0, 1'b1, 8'hF1, 1'b1, 1'b0, 16'h0000, 32'd2048, 16'd64, 32'd64, 8'h00, 4'd4, 8'd6},
        '{1'b1, 1'b0, 8'hBA, 1'b1, 1'b0, 16'h0001, 32'd2048, 16'd64, 32'd64, 8'h00, 4'd5, 8'd10},
        '{1'b0, 1'b1, 8'hCA, 1'b1, 1'b0, 16'h0001, 32'd2048, 16'd64, 32'd64, 8'h00, 4'd4, 8'd6},
        '{1'b0, 1'b1, 8'hA2, 1'b1, 1'b0, 16'h0000, 32'd2048, 16'd64, 32'd64, 8'h00, 4'd4, 8'd6},
        '{1'b0, 1'b1, 8'hC3, 1'b0, 1'b0, 16'h0000, 32'd0, 16'd0, 32'd0, 8'h00, 4'd4, 8'd6},
        '{1'b0, 1'b1, 8'h55, 1'b0, 1'b0, 16'h0000, 32'd0, 16'd0, 32'd0, 8'h00, 4'd4, 8'd6}
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int base_c, base_r;
        string tag;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state: R9 R10
        chk("R9", "done after reset", 32'(done), 32'd0);
        chk("R9", "fail after reset", 32'(fail), 32'd0);
        chk("R9", "page after reset", page_bytes, 32'd0);
        chk("R10", "req after reset", 32'(bus_req), 32'd0);

        for (int v = 0; v < NV; v++) begin
            id_ok = VECS[v].id_ok; pg_ok = VECS[v].pg_ok; dev = VECS[v].dev;
            m_feat = VECS[v].feat; m_page = VECS[v].page; m_spare = VECS[v].spare;
            m_ppb = VECS[v].ppb; m_acyc = VECS[v].acyc;
            base_c = n_cmd; base_r = n_rd;
            run_id();
            tag = VECS[v].onfi ? "R5" : (VECS[v].ok ? "R7" : "R8");
            chk(tag, "done", 32'(done), 32'(VECS[v].ok));
            chk(tag, "fail", 32'(fail), 32'(!VECS[v].ok));
            chk(tag, "src_onfi", 32'(src_onfi), 32'(VECS[v].onfi));
            chk(tag, "feat", 32'(feat), 32'(VECS[v].feat));
            chk(tag, "page_bytes", page_bytes, VECS[v].page);
            chk(tag, "spare_bytes", 32'(spare_bytes), 32'(VECS[v].spare));
            chk(tag, "pages_per_blk", pages_per_blk, VECS[v].ppb);
            chk(tag, "addr_cycles", 32'(addr_cycles), 32'(VECS[v].acyc));
            chk("R4", "command count", 32'(n_cmd - base_c), 32'(VECS[v].ncmd));
            chk("R4", "read count", 32'(n_rd - base_r), 32'(VECS[v].nrd));
            chk("R2", "first command", 32'(cmd_log[base_c % 64]), 32'hFF);
            chk("R3", "probe command", 32'(cmd_log[(base_c + 1) % 64]), 32'h90);
            if (!VECS[v].onfi) begin
                chk("R6", "second reset", 32'(cmd_log[(base_c + VECS[v].ncmd - 2) % 64]), 32'hFF);
                chk("R6", "legacy address", 32'(last_adr), 32'h00);
            end else begin
                chk("R3", "probe address", 32'(last_adr), 32'h20);
            end
            chk("R10", "no req at end", 32'(bus_req), 32'd0);
        end

        // R9: fail stays high with no start
        repeat (10) @(negedge clk);
        chk("R9", "fail sticky", 32'(fail), 32'd1);

        // R1: ready seen on the last allowed wait cycle
        id_ok = 1'b1; pg_ok = 1'b1;
        m_feat = 16'h0019; m_page = 32'd4096; m_spare = 16'd224; m_ppb = 32'd128; m_acyc = 8'h05;
        run_id();
        chk("R9", "done before restart", 32'(done), 32'd1);
        base_c = n_cmd;
        @(negedge clk) begin pwr_hold = 1'b1; start = 1'b1; end
        @(posedge clk);
        @(negedge clk) start = 1'b0;
        chk("R9", "done cleared by start", 32'(done), 32'd0);
        chk("R9", "results cleared by start", page_bytes, 32'd0);
        repeat (PWR_L - 1) @(posedge clk);
        @(negedge clk);
        chk("R1", "no bus cycle while waiting", 32'(n_cmd - base_c), 32'd0);
        chk("R1", "no req while waiting", 32'(bus_req), 32'd0);
        pwr_hold = 1'b0;
        begin
            int cyc = 0;
            while (!(done || fail) && cyc < 5000) begin @(negedge clk); cyc++; end
        end
        chk("R1", "ready on last wait cycle passes", 32'(done), 32'd1);

        // R1: ready one cycle too late
        base_c = n_cmd;
        @(negedge clk) begin pwr_hold = 1'b1; start = 1'b1; end
        @(posedge clk);
        @(negedge clk) start = 1'b0;
        repeat (PWR_L) @(posedge clk);
        @(negedge clk) pwr_hold = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "late ready fails", 32'(fail), 32'd1);
        chk("R1", "no bus cycle on timeout", 32'(n_cmd - base_c), 32'd0);

        // R2: reset busy exactly at the limit, then one beyond
        rst_busy = RST_L;
        run_id();
        chk("R2", "busy at limit passes", 32'(done), 32'd1);
        rst_busy = RST_L + 1;
        base_c = n_cmd;
        run_id();
        chk("R2", "busy past limit fails", 32'(fail), 32'd1);
        chk("R2", "only reset issued", 32'(n_cmd - base_c), 32'd1);
        rst_busy = 3;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule